// File: doc/BRIEF.md
# Integer Scalar ALU Evaluator

This block evaluates one integer operation per cycle on a pair of operands and produces `result = OP(src0, src1)` one clock later. The operation is selected by an 8-bit opcode, which comes from two separate ranges. A general range near zero holds bypass, bitwise, shift, arithmetic, logical, compare and magnitude operations. A dedicated integer range, whose top two bits are both set, holds explicitly signed or unsigned variants. Operands are 8, 16 or 32 bits wide, as chosen by a 4-bit data-type code. The type code also gives the signedness that compares, min/max and magnitude operations use at run time.

The second operand is either a register value or an immediate, picked by a shape bit. The caller is expected to order operands itself. The block never swaps them. An opcode the block does not implement raises an op error. A type code outside the integer set, or a signedness that the opcode forbids, raises a type error. In either case the result is forced to zero and the valid strobe still pulses, so a pipeline built around the block never loses a slot.

Top module: `alu_eval`

## Requirements
- R1: The outputs are registered with one cycle of latency: `out_valid` equals the `in_valid` of the previous cycle. Synchronous active-low reset clears `out_valid`, `result` and both error flags.
- R2: Type codes 0x2/0x3 are int8/uint8, 0x4/0x5 are int16/uint16 and 0x8/0x9 are int32/uint32 (even = signed). Operands are extended from that width, and the result is truncated to it with the upper result bits zero. Any other type code raises `err_dtype`.
- R3: With `src1_is_imm` = 1 the second operand is `imm`, otherwise `src1`. The unselected one has no effect.
- R4: 0x04 add, 0x05 subtract (src0 minus src1, never swapped) and 0x06 multiply wrap modulo 2^width. Multiply keeps the low half of the product.
- R5: 0x02 and 0x10 shift left, 0x03 shifts right with sign replication from the width's top bit, and 0x11 shifts right with zero fill. The shift amount is src1 modulo the width.
- R6: 0x00 passes src0, 0x01 is the bitwise NOT of src0, and 0x0A/0x0B/0x0C are bitwise AND/OR/XOR.
- R7: 0x0D/0x0E/0x0F reduce each operand to 1 if nonzero (else 0), then AND/OR/XOR the two bits.
- R8: Compares 0x12 EQ, 0x13 GT, 0x14 GE, 0x15 LE, 0x16 LT and 0x18 NE return exactly 0 or 1. The ordering is signed for signed type codes and unsigned otherwise.
- R9: 0x08 max, 0x09 min, 0x17 |src0-src1| and 0x19 |src0| follow the type's signedness. The magnitude of the most negative value wraps to itself.
- R10: 0x20 max(|a|,|b|), 0x21 min(|a|,|b|), 0x22 max(a,0), 0x23 a*a (low half) and 0x24 sign(a)*max(|a|,|b|), with sign(0)=0.
- R11: In the integer range, 0xC4 add, 0xC6 subtract, 0xC9 EQ and 0xCA NE accept either signedness. 0xC5 multiply, 0xCB abs-max, 0xCC abs-min, 0xCD abs-diff, 0xCE abs, 0xCF max, 0xD0 min and 0xD1..0xD4 GT/GE/LE/LT need a signed type. 0xD5 max, 0xD6 min, 0xD7..0xDA GT/GE/LE/LT and 0xDB multiply need an unsigned type. A mismatch raises `err_dtype`.
- R12: Every other opcode raises `err_op`. This covers 0x07, 0x1A..0x1F, 0x25..0xC3, 0xC7, 0xC8, 0xDC..0xFF.
- R13: Whenever either error flag is set, `result` is zero and `out_valid` still follows `in_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| op | input | 8 | Opcode |
| dtype | input | 4 | Operand type code |
| src1_is_imm | input | 1 | Selects `imm` instead of `src1` as second operand |
| src0 | input | 32 | First operand |
| src1 | input | 32 | Register second operand |
| imm | input | 32 | Immediate second operand |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| result | output | 32 | Truncated, zero-padded result |
| err_op | output | 1 | Unsupported opcode |
| err_dtype | output | 1 | Unsupported type code or signedness mismatch |

## Verification
Every one of the 256 opcodes is tried under all six integer type codes and one non-integer code. Operands are drawn from corner values: zero, one, the top-bit-only values and all-ones at each width. This separates signed from unsigned ordering, wrap from saturation, and zero fill from sign fill. Directed vectors pin cases that an independent reference model could share a blind spot with, such as int8 0x7F+1, the most negative magnitude, a shift amount beyond the width and 3-5 against 5-3. Alternating the shape bit with a deliberately different unused operand shows which input reached the datapath.

// File: rtl/alu_eval_pkg.sv
// Shared types for the scalar integer evaluator.
// Assumes a 32-bit operand word; narrow widths are slices of it.
package alu_eval_pkg;

    // Normalised operation kinds; both opcode ranges map onto these.
    typedef enum logic [4:0] {
        K_PASS, K_NOT, K_SHL, K_ASR, K_LSR,
        K_ADD, K_SUB, K_MUL, K_MAX, K_MIN,
        K_AND, K_OR, K_XOR, K_LAND, K_LOR, K_LXOR,
        K_EQ, K_GT, K_GE, K_LE, K_LT, K_NE,
        K_ADIFF, K_ABS, K_AMAX, K_AMIN, K_RELU, K_SQR, K_SCLAMP
    } alu_kind_e;

    // Signedness an opcode demands of the type code.
    typedef enum logic [1:0] {
        SGN_ANY, SGN_SIGNED, SGN_UNSIGNED
    } sgn_req_e;

    // Operand width selected by the type code.
    typedef enum logic [1:0] {
        WID_8, WID_16, WID_32
    } wid_e;

endpackage

// File: rtl/alu_op_decode.sv
// Maps the 8-bit opcode onto a normalised kind plus the signedness it needs.
// Assumes nothing about the type code; unknown opcodes clear op_ok.
module alu_op_decode
    import alu_eval_pkg::*;
(
    input  logic [7:0] op,
    output alu_kind_e  kind,
    output sgn_req_e   sgn_req,
    output logic       op_ok
);

    // Pure table decode of both opcode ranges.
    always_comb begin
        kind    = K_PASS;
        sgn_req = SGN_ANY;
        op_ok   = 1'b1;
        case (op)
            8'h00: kind = K_PASS;
            8'h01: kind = K_NOT;
            8'h02, 8'h10: kind = K_SHL;
            8'h03: kind = K_ASR;
            8'h11: kind = K_LSR;
            8'h04: kind = K_ADD;
            8'h05: kind = K_SUB;
            8'h06: kind = K_MUL;
            8'h08: kind = K_MAX;
            8'h09: kind = K_MIN;
            8'h0A: kind = K_AND;
            8'h0B: kind = K_OR;
            8'h0C: kind = K_XOR;
            8'h0D: kind = K_LAND;
            8'h0E: kind = K_LOR;
            8'h0F: kind = K_LXOR;
            8'h12: kind = K_EQ;
            8'h13: kind = K_GT;
            8'h14: kind = K_GE;
            8'h15: kind = K_LE;
            8'h16: kind = K_LT;
            8'h17: kind = K_ADIFF;
            8'h18: kind = K_NE;
            8'h19: kind = K_ABS;
            8'h20: kind = K_AMAX;
            8'h21: kind = K_AMIN;
            8'h22: kind = K_RELU;
            8'h23: kind = K_SQR;
            8'h24: kind = K_SCLAMP;
            // integer range, either signedness
            8'hC4: kind = K_ADD;
            8'hC6: kind = K_SUB;
            8'hC9: kind = K_EQ;
            8'hCA: kind = K_NE;
            // integer range, signed only
            8'hC5: begin kind = K_MUL;   sgn_req = SGN_SIGNED; end
            8'hCB: begin kind = K_AMAX;  sgn_req = SGN_SIGNED; end
            8'hCC: begin kind = K_AMIN;  sgn_req = SGN_SIGNED; end
            8'hCD: begin kind = K_ADIFF; sgn_req = SGN_SIGNED; end
            8'hCE: begin kind = K_ABS;   sgn_req = SGN_SIGNED; end
            8'hCF: begin kind = K_MAX;   sgn_req = SGN_SIGNED; end
            8'hD0: begin kind = K_MIN;   sgn_req = SGN_SIGNED; end
            8'hD1: begin kind = K_GT;    sgn_req = SGN_SIGNED; end
            8'hD2: begin kind = K_GE;    sgn_req = SGN_SIGNED; end
            8'hD3: begin kind = K_LE;    sgn_req = SGN_SIGNED; end
            8'hD4: begin kind = K_LT;    sgn_req = SGN_SIGNED; end
            // integer range, unsigned only
            8'hD5: begin kind = K_MAX;   sgn_req = SGN_UNSIGNED; end
            8'hD6: begin kind = K_MIN;   sgn_req = SGN_UNSIGNED; end
            8'hD7: begin kind = K_GT;    sgn_req = SGN_UNSIGNED; end
            8'hD8: begin kind = K_GE;    sgn_req = SGN_UNSIGNED; end
            8'hD9: begin kind = K_LE;    sgn_req = SGN_UNSIGNED; end
            8'hDA: begin kind = K_LT;    sgn_req = SGN_UNSIGNED; end
            8'hDB: begin kind = K_MUL;   sgn_req = SGN_UNSIGNED; end
            default: op_ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu_dtype_decode.sv
// Turns the 4-bit type code into width, signedness and a legality bit.
// Assumes only the six integer codes are legal.
module alu_dtype_decode
    import alu_eval_pkg::*;
(
    input  logic [3:0] dtype,
    output wid_e       wid,
    output logic       is_signed,
    output logic       dtype_ok
);

    // Width/sign lookup; even legal codes are signed.
    always_comb begin
        wid       = WID_32;
        is_signed = 1'b0;
        dtype_ok  = 1'b1;
        case (dtype)
            4'h2: begin wid = WID_8;  is_signed = 1'b1; end
            4'h3: wid = WID_8;
            4'h4: begin wid = WID_16; is_signed = 1'b1; end
            4'h5: wid = WID_16;
            4'h8: begin wid = WID_32; is_signed = 1'b1; end
            4'h9: wid = WID_32;
            default: dtype_ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu_operand_ext.sv
// Extends the selected width of a raw word to the wide internal datapath.
// Assumes DATA_W is 32 so the 8 and 16 bit slices exist.
module alu_operand_ext
    import alu_eval_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int EXT_W = DATA_W + 2
) (
    input  logic [DATA_W-1:0]       raw,
    input  wid_e                    wid,
    input  logic                    sign_ext,
    output logic signed [EXT_W-1:0] val
);

    // Sign or zero extension from the active width.
    always_comb begin
        case (wid)
            WID_8:   val = {{(EXT_W-8){sign_ext & raw[7]}}, raw[7:0]};
            WID_16:  val = {{(EXT_W-16){sign_ext & raw[15]}}, raw[15:0]};
            default: val = {{(EXT_W-DATA_W){sign_ext & raw[DATA_W-1]}}, raw};
        endcase
    end

endmodule

// File: rtl/alu_compute.sv
// Combinational evaluation of one normalised kind on extended operands.
// Assumes operands already extended; output masked to the active width.
module alu_compute
    import alu_eval_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int EXT_W = DATA_W + 2,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  alu_kind_e               kind,
    input  wid_e                    wid,
    input  logic signed [EXT_W-1:0] va,
    input  logic signed [EXT_W-1:0] vb,
    input  logic signed [EXT_W-1:0] a_sx,
    input  logic signed [EXT_W-1:0] a_zx,
    output logic [DATA_W-1:0]       res
);

    logic signed [EXT_W-1:0] abs_a, abs_b, diff, abs_diff, mag_max, mag_min, r;
    logic [DATA_W-1:0]       prod, prod_sq, dmask;
    logic [SH_W-1:0]         sh, shmask;
    logic                    nz_a, nz_b;

    // Width-dependent masks for result and shift amount.
    always_comb begin
        case (wid)
            WID_8:   begin dmask = {{(DATA_W-8){1'b0}}, 8'hFF};    shmask = SH_W'(7);  end
            WID_16:  begin dmask = {{(DATA_W-16){1'b0}}, 16'hFFFF}; shmask = SH_W'(15); end
            default: begin dmask = '1;                              shmask = '1;        end
        endcase
    end

    // Shared magnitude, product and boolean terms.
    always_comb begin
        sh       = vb[SH_W-1:0] & shmask;
        abs_a    = (va < 0) ? -va : va;
        abs_b    = (vb < 0) ? -vb : vb;
        diff     = va - vb;
        abs_diff = (diff < 0) ? -diff : diff;
        mag_max  = (abs_a > abs_b) ? abs_a : abs_b;
        mag_min  = (abs_a > abs_b) ? abs_b : abs_a;
        prod     = va[DATA_W-1:0] * vb[DATA_W-1:0];
        prod_sq  = va[DATA_W-1:0] * va[DATA_W-1:0];
        nz_a     = (va != 0);
        nz_b     = (vb != 0);
    end

    // Kind selection.
    always_comb begin
        r = '0;
        case (kind)
            K_PASS:  r = va;
            K_NOT:   r = ~va;
            K_SHL:   r = a_zx << sh;
            K_ASR:   r = a_sx >>> sh;
            K_LSR:   r = a_zx >> sh;
            K_ADD:   r = va + vb;
            K_SUB:   r = va - vb;
            K_MUL:   r = $signed({{(EXT_W-DATA_W){1'b0}}, prod});
            K_SQR:   r = $signed({{(EXT_W-DATA_W){1'b0}}, prod_sq});
            K_MAX:   r = (va > vb) ? va : vb;
            K_MIN:   r = (va < vb) ? va : vb;
            K_AND:   r = va & vb;
            K_OR:    r = va | vb;
            K_XOR:   r = va ^ vb;
            K_LAND:  r[0] = nz_a & nz_b;
            K_LOR:   r[0] = nz_a | nz_b;
            K_LXOR:  r[0] = nz_a ^ nz_b;
            K_EQ:    r[0] = (va == vb);
            K_NE:    r[0] = (va != vb);
            K_GT:    r[0] = (va > vb);
            K_GE:    r[0] = (va >= vb);
            K_LE:    r[0] = (va <= vb);
            K_LT:    r[0] = (va < vb);
            K_ADIFF: r = abs_diff;
            K_ABS:   r = abs_a;
            K_AMAX:  r = mag_max;
            K_AMIN:  r = mag_min;
            K_RELU:  r = (va > 0) ? va : '0;
            K_SCLAMP: begin
                if (va < 0)       r = -mag_max;
                else if (va == 0) r = '0;
                else              r = mag_max;
            end
            default: r = '0;
        endcase
    end

    assign res = r[DATA_W-1:0] & dmask;

endmodule

// File: rtl/alu_eval.sv
// Top of the scalar integer evaluator: decode, extend, compute, register.
// Assumes the caller orders operands; one result per accepted request.
module alu_eval
    import alu_eval_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int EXT_W = DATA_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        op,
    input  logic [3:0]        dtype,
    input  logic              src1_is_imm,
    input  logic [DATA_W-1:0] src0,
    input  logic [DATA_W-1:0] src1,
    input  logic [DATA_W-1:0] imm,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              err_op,
    output logic              err_dtype
);

    alu_kind_e               kind;
    sgn_req_e                sgn_req;
    wid_e                    wid;
    logic                    op_ok, dtype_ok, is_signed, sgn_bad, any_err;
    logic [DATA_W-1:0]       opnd1, res_c;
    logic signed [EXT_W-1:0] va, vb, a_sx, a_zx;

    assign opnd1 = src1_is_imm ? imm : src1;

    alu_op_decode    u_opdec (.op(op), .kind(kind), .sgn_req(sgn_req), .op_ok(op_ok));
    alu_dtype_decode u_dtdec (.dtype(dtype), .wid(wid), .is_signed(is_signed), .dtype_ok(dtype_ok));

    alu_operand_ext #(.DATA_W(DATA_W)) u_ext_a  (.raw(src0),  .wid(wid), .sign_ext(is_signed), .val(va));
    alu_operand_ext #(.DATA_W(DATA_W)) u_ext_b  (.raw(opnd1), .wid(wid), .sign_ext(is_signed), .val(vb));
    alu_operand_ext #(.DATA_W(DATA_W)) u_ext_as (.raw(src0),  .wid(wid), .sign_ext(1'b1),      .val(a_sx));
    alu_operand_ext #(.DATA_W(DATA_W)) u_ext_az (.raw(src0),  .wid(wid), .sign_ext(1'b0),      .val(a_zx));

    alu_compute #(.DATA_W(DATA_W)) u_core (
        .kind(kind), .wid(wid), .va(va), .vb(vb), .a_sx(a_sx), .a_zx(a_zx), .res(res_c)
    );

    // Signedness demanded by the opcode versus the type code.
    always_comb begin
        sgn_bad = 1'b0;
        if (op_ok && sgn_req == SGN_SIGNED)   sgn_bad = !is_signed;
        if (op_ok && sgn_req == SGN_UNSIGNED) sgn_bad = is_signed;
    end

    assign any_err = !op_ok || !dtype_ok || sgn_bad;

    // Output register stage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            err_op    <= 1'b0;
            err_dtype <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result    <= any_err ? '0 : res_c;
                err_op    <= !op_ok;
                err_dtype <= !dtype_ok || sgn_bad;
            end
        end
    end

endmodule

// File: rtl/alu_eval_chk.sv
// Property checker for alu_eval, attached by bind below.
// Assumes the port names of alu_eval.
module alu_eval_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [7:0]        op,
    input logic [3:0]        dtype,
    input logic              out_valid,
    input logic [DATA_W-1:0] result,
    input logic              err_op,
    input logic              err_dtype
);

    logic int_code, cmp_code, rsv_code;
    assign int_code = (dtype == 4'h2) || (dtype == 4'h3) || (dtype == 4'h4) ||
                      (dtype == 4'h5) || (dtype == 4'h8) || (dtype == 4'h9);
    assign cmp_code = (op >= 8'h12 && op <= 8'h16) || (op == 8'h18);
    assign rsv_code = (op == 8'h1E) || (op == 8'h1F) || (op >= 8'h25 && op <= 8'hC3);

    AST_VALID_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R1
    AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (err_op || err_dtype) |-> result == '0); // R13
    AST_CMP_BOOL: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && cmp_code |=> result <= 1); // R8
    AST_NARROW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (dtype == 4'h2 || dtype == 4'h3) |=> result[DATA_W-1:8] == '0); // R2
    AST_BAD_DTYPE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !int_code |=> err_dtype); // R2
    AST_RESERVED_OP: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && rsv_code |=> err_op); // R12

endmodule

bind alu_eval alu_eval_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/alu_eval_bench.sv
// Scoreboard bench: driver pushes model expectations, monitor compares.
module alu_eval_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  op = '0;
    logic [3:0]  dtype = '0;
    logic        src1_is_imm = 1'b0;
    logic [31:0] src0 = '0, src1 = '0, imm = '0;
    logic        out_valid, err_op, err_dtype;
    logic [31:0] result;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [7:0]  op;
        logic [3:0]  dt;
        logic [33:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #10 clk = ~clk; // 50 MHz

    alu_eval u_alu_eval (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .dtype(dtype),
        .src1_is_imm(src1_is_imm), .src0(src0), .src1(src1), .imm(imm),
        .out_valid(out_valid), .result(result), .err_op(err_op), .err_dtype(err_dtype)
    );

    // Reference model written from the requirements: {err_op, err_dtype, result}.
    function automatic logic [33:0] model(input logic [7:0] o, input logic [3:0] dt,
                                          input logic [31:0] x, input logic [31:0] y);
        int w = 32; bit sg, dok = 1, bad = 0, edt; int need = 0; int sh;
        longint M, ua, ub, sa, sb2, a, b, r = 0, aa, ab, m, d;
        case (dt)
            4'h2, 4'h3: w = 8;
            4'h4, 4'h5: w = 16;
            4'h8, 4'h9: w = 32;
            default: dok = 0;
        endcase
        sg  = (dt == 4'h2 || dt == 4'h4 || dt == 4'h8);
        M   = (longint'(1) << w) - 1;
        ua  = longint'({32'd0, x}) & M;
        ub  = longint'({32'd0, y}) & M;
        sa  = ((ua >> (w-1)) & 1) != 0 ? ua - (M + 1) : ua;
        sb2 = ((ub >> (w-1)) & 1) != 0 ? ub - (M + 1) : ub;
        a   = sg ? sa : ua;
        b   = sg ? sb2 : ub;
        sh  = int'(ub & longint'(w - 1));
        aa  = a < 0 ? -a : a;
        ab  = b < 0 ? -b : b;
        m   = aa > ab ? aa : ab;
        d   = a - b; if (d < 0) d = -d;
        case (o)
            8'hC5, 8'hCB, 8'hCC, 8'hCD, 8'hCE, 8'hCF, 8'hD0,
            8'hD1, 8'hD2, 8'hD3, 8'hD4: need = 1;
            8'hD5, 8'hD6, 8'hD7, 8'hD8, 8'hD9, 8'hDA, 8'hDB: need = 2;
            default: need = 0;
        endcase
        case (o)
            8'h00: r = ua;
            8'h01: r = ~ua;
            8'h02, 8'h10: r = ua << sh;
            8'h03: r = sa >>> sh;
            8'h11: r = ua >> sh;
            8'h04, 8'hC4: r = a + b;
            8'h05, 8'hC6: r = a - b;
            8'h06, 8'hC5, 8'hDB: r = ua * ub;
            8'h08, 8'hCF, 8'hD5: r = a > b ? a : b;
            8'h09, 8'hD0, 8'hD6: r = a < b ? a : b;
            8'h0A: r = ua & ub;
            8'h0B: r = ua | ub;
            8'h0C: r = ua ^ ub;
            8'h0D: r = longint'((ua != 0) && (ub != 0));
            8'h0E: r = longint'((ua != 0) || (ub != 0));
            8'h0F: r = longint'((ua != 0) ^ (ub != 0));
            8'h12, 8'hC9: r = longint'(a == b);
            8'h13, 8'hD1, 8'hD7: r = longint'(a > b);
            8'h14, 8'hD2, 8'hD8: r = longint'(a >= b);
            8'h15, 8'hD3, 8'hD9: r = longint'(a <= b);
            8'h16, 8'hD4, 8'hDA: r = longint'(a < b);
            8'h18, 8'hCA: r = longint'(a != b);
            8'h17, 8'hCD: r = d;
            8'h19, 8'hCE: r = aa;
            8'h20, 8'hCB: r = m;
            8'h21, 8'hCC: r = aa > ab ? ab : aa;
            8'h22: r = a > 0 ? a : 0;
            8'h23: r = ua * ua;
            8'h24: r = a < 0 ? -m : (a == 0 ? 0 : m);
            default: bad = 1;
        endcase
        edt = !dok || (!bad && ((need == 1 && !sg) || (need == 2 && sg)));
        if (bad || edt) r = 0;
        return {bad, edt, 32'(r & M)};
    endfunction

    // Requirement tag for an opcode/type pair.
    function automatic string req_of(input logic [7:0] o, input logic [3:0] dt);
        if (!(dt inside {4'h2, 4'h3, 4'h4, 4'h5, 4'h8, 4'h9})) return "R2";
        case (o)
            8'h00, 8'h01, 8'h0A, 8'h0B, 8'h0C: return "R6";
            8'h02, 8'h03, 8'h10, 8'h11: return "R5";
            8'h04, 8'h05, 8'h06: return "R4";
            8'h08, 8'h09, 8'h17, 8'h19: return "R9";
            8'h0D, 8'h0E, 8'h0F: return "R7";
            8'h12, 8'h13, 8'h14, 8'h15, 8'h16, 8'h18: return "R8";
            8'h20, 8'h21, 8'h22, 8'h23, 8'h24: return "R10";
            default: return ((o >= 8'hC4 && o <= 8'hDB) && o != 8'hC7 && o != 8'hC8
                             && o != 8'hDC && o != 8'hDD) ? "R11" : "R12";
        endcase
    endfunction

    // Driver: one request per cycle, expectation pushed with it.
    task automatic send(input logic [7:0] o, input logic [3:0] dt, input bit shp,
                        input logic [31:0] x, input logic [31:0] yr, input logic [31:0] yi,
                        input logic [33:0] exp, input string tag);
        item_t it;
        @(negedge clk);
        in_valid = 1'b1; op = o; dtype = dt; src1_is_imm = shp;
        src0 = x; src1 = yr; imm = yi;
        it.op = o; it.dt = dt; it.exp = exp; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic send_m(input logic [7:0] o, input logic [3:0] dt, input bit shp,
                          input logic [31:0] x, input logic [31:0] yr, input logic [31:0] yi);
        send(o, dt, shp, x, yr, yi, model(o, dt, x, shp ? yi : yr), req_of(o, dt));
    endtask

    // Monitor: compares each produced result against the oldest expectation.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            item_t it;
            checks++;
            if (sb.size() == 0) begin
                fails++;
                $display("FAIL R1 unexpected out_valid: actual 1 expected 0");
            end else begin
                it = sb.pop_front();
                if ({err_op, err_dtype, result} !== it.exp) begin // R13 zero-on-error folded in
                    fails++;
                    $display("FAIL %s op=%h dt=%h actual %h expected %h",
                             it.tag, it.op, it.dt, {err_op, err_dtype, result}, it.exp);
                end
            end
        end
    end

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog expired: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    logic [31:0] corner [0:8];

    initial begin
        corner[0] = 32'h0;        corner[1] = 32'h1;        corner[2] = 32'h80;
        corner[3] = 32'hFF;       corner[4] = 32'h7FFF;     corner[5] = 32'h8000;
        corner[6] = 32'hFFFFFFFF; corner[7] = 32'h80000000; corner[8] = 32'h7FFFFFFF;

        repeat (3) @(negedge clk);
        checks++; // R1 reset state
        if ({out_valid, err_op, err_dtype, result} !== 35'd0) begin
            fails++;
            $display("FAIL R1 reset state: actual %h expected 0",
                     {out_valid, err_op, err_dtype, result});
        end
        @(negedge clk) rst_n = 1'b1;

        // Directed literals
        send(8'h04, 4'h2, 0, 32'h7F, 32'h1, 32'h0, {2'b00, 32'h80}, "R4");        // int8 wrap
        send(8'h05, 4'h2, 0, 32'h3, 32'h5, 32'h0, {2'b00, 32'hFE}, "R4");         // 3-5 order
        send(8'h05, 4'h2, 0, 32'h5, 32'h3, 32'h0, {2'b00, 32'h02}, "R4");
        send(8'h06, 4'h8, 0, 32'h10000, 32'h10001, 32'h0, {2'b00, 32'h10000}, "R4");
        send(8'h03, 4'h5, 0, 32'h8000, 32'h4, 32'h0, {2'b00, 32'hF800}, "R5");    // sign fill
        send(8'h11, 4'h4, 0, 32'h8000, 32'h4, 32'h0, {2'b00, 32'h0800}, "R5");    // zero fill
        send(8'h02, 4'h4, 0, 32'h1, 32'h11, 32'h0, {2'b00, 32'h2}, "R5");         // 17 mod 16
        send(8'h13, 4'h3, 0, 32'h80, 32'h1, 32'h0, {2'b00, 32'h1}, "R8");         // unsigned GT
        send(8'h13, 4'h2, 0, 32'h80, 32'h1, 32'h0, {2'b00, 32'h0}, "R8");         // signed GT
        send(8'h0F, 4'h9, 0, 32'h5, 32'h9, 32'h0, {2'b00, 32'h0}, "R7");
        send(8'h19, 4'h2, 0, 32'h80, 32'h0, 32'h0, {2'b00, 32'h80}, "R9");        // abs wrap
        send(8'h24, 4'h2, 0, 32'hFD, 32'hA, 32'h0, {2'b00, 32'hF6}, "R10");       // -3,10 -> -10
        send(8'h01, 4'h5, 0, 32'h1234_00FF, 32'h0, 32'h0, {2'b00, 32'hFF00}, "R6");
        send(8'hCF, 4'h3, 0, 32'h1, 32'h2, 32'h0, {2'b01, 32'h0}, "R11");         // signed op, unsigned type
        send(8'hD5, 4'h2, 0, 32'h1, 32'h2, 32'h0, {2'b01, 32'h0}, "R11");
        send(8'hC4, 4'h9, 0, 32'hFFFFFFFF, 32'h2, 32'h0, {2'b00, 32'h1}, "R11");
        send(8'h07, 4'h8, 0, 32'h6, 32'h2, 32'h0, {2'b10, 32'h0}, "R12");
        send(8'h04, 4'h6, 0, 32'h6, 32'h2, 32'h0, {2'b01, 32'h0}, "R2");          // R13 zeroed
        send(8'h04, 4'h8, 1, 32'h10, 32'h1000, 32'h3, {2'b00, 32'h13}, "R3");     // imm used
        send(8'h04, 4'h8, 0, 32'h10, 32'h1000, 32'h3, {2'b00, 32'h1010}, "R3");   // reg used

        // Sweep every opcode over integer codes and one non-integer code
        for (int o = 0; o < 256; o++) begin
            for (int di = 0; di < 7; di++) begin
                logic [3:0] dt;
                case (di)
                    0: dt = 4'h2; 1: dt = 4'h3; 2: dt = 4'h4; 3: dt = 4'h5;
                    4: dt = 4'h8; 5: dt = 4'h9; default: dt = 4'hA;
                endcase
                for (int v = 0; v < 3; v++) begin
                    logic [31:0] x, y, z;
                    x = (v == 2) ? $urandom : corner[(o + di + v) % 9];
                    y = (v == 1) ? $urandom : corner[(o * 3 + di * 5 + v) % 9];
                    z = ~y;
                    send_m(8'(o), dt, v[0], x, v[0] ? z : y, v[0] ? y : z);
                end
            end
        end

        @(negedge clk) in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        checks++; // R1 idle strobe and drained scoreboard
        if (out_valid !== 1'b0 || sb.size() != 0) begin
            fails++;
            $display("FAIL R1 idle: actual valid=%b pending=%0d expected valid=0 pending=0",
                     out_valid, sb.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule